// File: doc/BRIEF.md
# DMA Width-Adapting Data Path

This block is the data-phase stage of a DMA bus master. An address-phase stage, running one cycle ahead, hands it a transfer command that holds the source and destination access sizes and the low address bits of the first source and destination beats. The block collects read data from the system read bus into a staging buffer as wide as the bus. It realigns each byte by the low address bits and drives the result on the write data bus with a byte strobe.

When the two sizes match, one read is followed by one write. When they differ, the smaller side makes several accesses for each access of the larger side. Narrow reads are packed into one wide write, or one wide read is split into narrow writes. The data unit moved per command is the larger of the two sizes. The buffer fills completely before the first write leaves. A stall input freezes the whole data path.

Top module: `dma_width_dp`

## Requirements
- R1: While reset is asserted and after its release, `cmd_ready_o` is 1, `rd_ready_o` is 0, `wr_valid_o` is 0 and `wr_strb_o` is all zero.
- R2: A size field gives log2 of the byte count (0 means 1 byte, up to log2(BUS_BYTES)). The unit length is T = 2^max(ssize, dsize). A command is taken only when `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` is high only while no command is in progress.
- R3: Each command produces exactly T/S read handshakes and then exactly T/D write beats, where S = 2^ssize and D = 2^dsize. No write beat appears before the last read handshake has completed.
- R4: In read handshake k (from 0), byte j (j < S) is taken from read lane (soff + k·S + j) mod BUS_BYTES. It becomes byte k·S + j of the unit, so the buffer fills in ascending little-endian order.
- R5: Write beat m (from 0) sets strobe bits exactly at lanes (doff + m·D + j) mod BUS_BYTES for j < D. Each such lane carries unit byte m·D + j, and every lane without a strobe is driven to zero.
- R6: Read data is stored only in a cycle where `rd_valid_i` and `rd_ready_o` are both high. `rd_ready_o` is high only while reads are still owed and `stall_i` is low.
- R7: While `stall_i` is high, the staging buffer keeps its contents, no read is accepted, and a pending write beat keeps `wr_valid_o`, `wr_data_o` and `wr_strb_o` unchanged and is not consumed. A write beat is consumed in a cycle where `wr_valid_o` is high and `stall_i` is low.
- R8: In the cycle after the last write beat of a command is consumed, `cmd_ready_o` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Transfer command offered |
| cmd_ready_o | output | 1 | Block idle, command taken on this edge |
| cmd_ssize_i | input | $clog2($clog2(BUS_BYTES)+1) | Source size, log2 bytes |
| cmd_dsize_i | input | $clog2($clog2(BUS_BYTES)+1) | Destination size, log2 bytes |
| cmd_soff_i | input | $clog2(BUS_BYTES) | Lane of first source byte, aligned to source size |
| cmd_doff_i | input | $clog2(BUS_BYTES) | Lane of first destination byte, aligned to destination size |
| rd_valid_i | input | 1 | Read data beat present |
| rd_ready_o | output | 1 | Read beat accepted when valid |
| rd_data_i | input | 8*BUS_BYTES | System read data bus |
| stall_i | input | 1 | Freezes the data path |
| wr_valid_o | output | 1 | Write beat present |
| wr_data_o | output | 8*BUS_BYTES | System write data bus |
| wr_strb_o | output | BUS_BYTES | Byte lanes carried by the write beat |

## Verification
The bench builds the block with BUS_BYTES set to 8, so sizes run from 1 to 8 bytes. All sixteen source and destination size pairs are covered, from eight single-byte reads packed into one 8-byte write to one 8-byte read split into eight byte writes. With random aligned offsets on a bus this narrow, a unit often wraps past the top lane, which exercises the modulo lane arithmetic in both rotators. Random stalls and random gaps between reads, with junk data on the bus during the gaps, are applied in later passes.

// File: rtl/dma_dp_pkg.sv
package dma_dp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } dp_state_e;
endpackage

// File: rtl/dma_dp_rot.sv
module dma_dp_rot #(
  parameter int unsigned LANES = 32,
  parameter int unsigned EW    = 8,
  parameter bit          LEFT  = 1'b0
) (
  input  logic [EW*LANES-1:0]        din_i,
  input  logic [$clog2(LANES)-1:0]   amt_i,
  output logic [EW*LANES-1:0]        dout_o
);
  localparam int unsigned AW = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] src;
    if (LEFT) begin : g_left
      assign src = AW'(i) - amt_i;
    end else begin : g_right
      assign src = AW'(i) + amt_i;
    end
    assign dout_o[EW*i +: EW] = din_i[EW*src +: EW];
  end
endmodule

// File: rtl/dma_dp_ctrl.sv
module dma_dp_ctrl
  import dma_dp_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                cmd_valid_i,
  output logic                                cmd_ready_o,
  input  logic [$clog2($clog2(BUS_BYTES)+1)-1:0] cmd_ssize_i,
  input  logic [$clog2($clog2(BUS_BYTES)+1)-1:0] cmd_dsize_i,
  input  logic [$clog2(BUS_BYTES)-1:0]        cmd_soff_i,
  input  logic [$clog2(BUS_BYTES)-1:0]        cmd_doff_i,
  input  logic                                rd_valid_i,
  output logic                                rd_ready_o,
  input  logic                                stall_i,
  output logic                                wr_valid_o,
  output logic [BUS_BYTES-1:0]                fill_en_o,
  output logic [BUS_BYTES-1:0]                drain_sel_o,
  output logic [$clog2(BUS_BYTES)-1:0]        soff_o,
  output logic [$clog2(BUS_BYTES)-1:0]        doff_o,
  output logic [$clog2($clog2(BUS_BYTES)+1)-1:0] dsize_o
);
  localparam int unsigned OFFW = $clog2(BUS_BYTES);
  localparam int unsigned SZW  = $clog2(OFFW + 1);

  dp_state_e       state_q;
  logic [OFFW-1:0] cnt_q, soff_q, doff_q;
  logic [SZW-1:0]  ssz_q, dsz_q, tsz;
  logic            rd_fire, wr_fire, rd_last, wr_last;

  // contiguous run of 2^sz ones starting at lane 0
  function automatic logic [BUS_BYTES-1:0] unit_mask(input logic [SZW-1:0] sz);
    logic [BUS_BYTES-1:0] one;
    one = BUS_BYTES'(1);
    return (one << (32'd1 << sz)) - one;
  endfunction

  assign tsz         = (ssz_q > dsz_q) ? ssz_q : dsz_q;
  assign rd_last     = (cnt_q == OFFW'((32'd1 << (tsz - ssz_q)) - 32'd1));
  assign wr_last     = (cnt_q == OFFW'((32'd1 << (tsz - dsz_q)) - 32'd1));
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign rd_ready_o  = (state_q == ST_FILL) && !stall_i;
  assign wr_valid_o  = (state_q == ST_DRAIN);
  assign rd_fire     = rd_valid_i && rd_ready_o;
  assign wr_fire     = wr_valid_o && !stall_i;
  assign fill_en_o   = rd_fire ? (unit_mask(ssz_q) << (cnt_q << ssz_q)) : '0;
  assign drain_sel_o = wr_valid_o ? (unit_mask(dsz_q) << (cnt_q << dsz_q)) : '0;
  assign soff_o      = soff_q;
  assign doff_o      = doff_q;
  assign dsize_o     = dsz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ssz_q   <= '0;
      dsz_q   <= '0;
      soff_q  <= '0;
      doff_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          ssz_q   <= cmd_ssize_i;
          dsz_q   <= cmd_dsize_i;
          soff_q  <= cmd_soff_i;
          doff_q  <= cmd_doff_i;
          cnt_q   <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (rd_fire) begin
          if (rd_last) begin
            cnt_q   <= '0;
            state_q <= ST_DRAIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DRAIN: if (wr_fire) begin
          if (wr_last) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_ready_o) |-> $past(cmd_valid_i));
  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ready_o && wr_valid_o));
  a_r6_ready_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !rd_ready_o);
endmodule

// File: rtl/dma_dp_stage.sv
module dma_dp_stage #(
  parameter int unsigned BUS_BYTES = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [8*BUS_BYTES-1:0]       rd_data_i,
  input  logic [$clog2(BUS_BYTES)-1:0] soff_i,
  input  logic [BUS_BYTES-1:0]         fill_en_i,
  output logic [8*BUS_BYTES-1:0]       stage_o
);
  logic [8*BUS_BYTES-1:0] rd_rot, stage_q;

  // unit byte b always comes from read lane (soff + b) mod BUS_BYTES
  dma_dp_rot #(.LANES(BUS_BYTES), .EW(8), .LEFT(1'b0)) u_rd_rot (
    .din_i  (rd_data_i),
    .amt_i  (soff_i),
    .dout_o (rd_rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      for (int b = 0; b < BUS_BYTES; b++) begin
        if (fill_en_i[b]) stage_q[8*b +: 8] <= rd_rot[8*b +: 8];
      end
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/dma_dp_align.sv
module dma_dp_align #(
  parameter int unsigned BUS_BYTES = 32
) (
  input  logic [8*BUS_BYTES-1:0]       stage_i,
  input  logic [$clog2(BUS_BYTES)-1:0] doff_i,
  input  logic [BUS_BYTES-1:0]         drain_sel_i,
  output logic [8*BUS_BYTES-1:0]       wr_data_o,
  output logic [BUS_BYTES-1:0]         wr_strb_o
);
  logic [8*BUS_BYTES-1:0] data_rot;
  logic [BUS_BYTES-1:0]   strb_rot;

  dma_dp_rot #(.LANES(BUS_BYTES), .EW(8), .LEFT(1'b1)) u_data_rot (
    .din_i  (stage_i),
    .amt_i  (doff_i),
    .dout_o (data_rot)
  );

  dma_dp_rot #(.LANES(BUS_BYTES), .EW(1), .LEFT(1'b1)) u_strb_rot (
    .din_i  (drain_sel_i),
    .amt_i  (doff_i),
    .dout_o (strb_rot)
  );

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_mask
    assign wr_data_o[8*l +: 8] = strb_rot[l] ? data_rot[8*l +: 8] : 8'h00;
  end
  assign wr_strb_o = strb_rot;
endmodule

// File: rtl/dma_width_dp.sv
module dma_width_dp #(
  parameter int unsigned BUS_BYTES = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cmd_valid_i,
  output logic                                   cmd_ready_o,
  input  logic [$clog2($clog2(BUS_BYTES)+1)-1:0] cmd_ssize_i,
  input  logic [$clog2($clog2(BUS_BYTES)+1)-1:0] cmd_dsize_i,
  input  logic [$clog2(BUS_BYTES)-1:0]           cmd_soff_i,
  input  logic [$clog2(BUS_BYTES)-1:0]           cmd_doff_i,
  input  logic                                   rd_valid_i,
  output logic                                   rd_ready_o,
  input  logic [8*BUS_BYTES-1:0]                 rd_data_i,
  input  logic                                   stall_i,
  output logic                                   wr_valid_o,
  output logic [8*BUS_BYTES-1:0]                 wr_data_o,
  output logic [BUS_BYTES-1:0]                   wr_strb_o
);
  localparam int unsigned OFFW = $clog2(BUS_BYTES);
  localparam int unsigned SZW  = $clog2(OFFW + 1);

  logic [BUS_BYTES-1:0]   fill_en, drain_sel;
  logic [OFFW-1:0]        soff, doff;
  logic [SZW-1:0]         dsize;
  logic [8*BUS_BYTES-1:0] stage;

  dma_dp_ctrl #(.BUS_BYTES(BUS_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_ssize_i (cmd_ssize_i),
    .cmd_dsize_i (cmd_dsize_i),
    .cmd_soff_i  (cmd_soff_i),
    .cmd_doff_i  (cmd_doff_i),
    .rd_valid_i  (rd_valid_i),
    .rd_ready_o  (rd_ready_o),
    .stall_i     (stall_i),
    .wr_valid_o  (wr_valid_o),
    .fill_en_o   (fill_en),
    .drain_sel_o (drain_sel),
    .soff_o      (soff),
    .doff_o      (doff),
    .dsize_o     (dsize)
  );

  dma_dp_stage #(.BUS_BYTES(BUS_BYTES)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_i (rd_data_i),
    .soff_i    (soff),
    .fill_en_i (fill_en),
    .stage_o   (stage)
  );

  dma_dp_align #(.BUS_BYTES(BUS_BYTES)) u_align (
    .stage_i     (stage),
    .doff_i      (doff),
    .drain_sel_i (drain_sel),
    .wr_data_o   (wr_data_o),
    .wr_strb_o   (wr_strb_o)
  );

  a_r5_strb_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($countones(wr_strb_o) == (32'd1 << dsize)));
  a_r1_quiet_strb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> (wr_strb_o == '0));
  a_r6_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_i && rd_ready_o) |=> $stable(stage));
  a_r7_buf_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(stage));
  a_r7_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && stall_i) |=> (wr_valid_o && $stable(wr_data_o) && $stable(wr_strb_o)));
endmodule

// File: tb/dma_width_dp_bench.sv
module dma_width_dp_bench;
  localparam int BB = 8;
  localparam int OW = $clog2(BB);
  localparam int SW = $clog2(OW + 1);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid_i = 1'b0;
  logic            cmd_ready_o;
  logic [SW-1:0]   cmd_ssize_i = '0;
  logic [SW-1:0]   cmd_dsize_i = '0;
  logic [OW-1:0]   cmd_soff_i = '0;
  logic [OW-1:0]   cmd_doff_i = '0;
  logic            rd_valid_i = 1'b0;
  logic            rd_ready_o;
  logic [8*BB-1:0] rd_data_i = '0;
  logic            stall_i = 1'b0;
  logic            wr_valid_o;
  logic [8*BB-1:0] wr_data_o;
  logic [BB-1:0]   wr_strb_o;

  always #5 clk = ~clk;

  dma_width_dp #(.BUS_BYTES(BB)) u_dma_width_dp (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_ssize_i(cmd_ssize_i), .cmd_dsize_i(cmd_dsize_i),
    .cmd_soff_i(cmd_soff_i), .cmd_doff_i(cmd_doff_i),
    .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o), .rd_data_i(rd_data_i),
    .stall_i(stall_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_strb_o(wr_strb_o)
  );

  typedef struct packed {
    logic [8*BB-1:0] d;
    logic [BB-1:0]   s;
  } beat_t;

  beat_t exp_q[$];
  int    n_chk = 0, n_bad = 0, wr_cnt = 0;
  bit    reads_done = 1'b0, stall_en = 1'b0, chk_idle = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    stall_i = stall_en && ($urandom % 4 == 0);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (chk_idle) begin
        chk(cmd_ready_o, "R8 ready after last write", 64'(cmd_ready_o), 64'd1);
        chk_idle = 1'b0;
      end
      if (stall_i)
        chk(!rd_ready_o, "R6 R7 read ready under stall", 64'(rd_ready_o), 64'd0);
      if (wr_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write beat", 64'(wr_strb_o), 64'd0);
        end else begin
          chk(reads_done, "R3 write before reads complete", 64'(reads_done), 64'd1);
          chk(wr_strb_o == exp_q[0].s, stall_i ? "R7 held strobe" : "R5 strobe",
              64'(wr_strb_o), 64'(exp_q[0].s));
          chk(wr_data_o == exp_q[0].d, stall_i ? "R7 held data" : "R4 R5 data",
              64'(wr_data_o), 64'(exp_q[0].d));
          if (!stall_i) begin
            void'(exp_q.pop_front());
            wr_cnt++;
            if (exp_q.size() == 0) chk_idle = 1'b1;
          end
        end
      end
    end
  end

  task automatic xfer(input int ssz, input int dsz, input int sa, input int da);
    int S, D, T;
    logic [7:0] pay [BB];
    beat_t b;
    S = 1 << ssz;
    D = 1 << dsz;
    T = (S > D) ? S : D;
    for (int j = 0; j < BB; j++) pay[j] = 8'($urandom);
    for (int m = 0; m < T / D; m++) begin
      b = '0;
      for (int j = 0; j < D; j++) begin
        b.s[(da + m*D + j) % BB] = 1'b1;
        b.d[8*((da + m*D + j) % BB) +: 8] = pay[m*D + j];
      end
      exp_q.push_back(b);
    end
    reads_done = 1'b0;
    wr_cnt = 0;
    @(posedge clk); #2;
    cmd_valid_i = 1'b1;
    cmd_ssize_i = SW'(ssz);
    cmd_dsize_i = SW'(dsz);
    cmd_soff_i  = OW'(sa);
    cmd_doff_i  = OW'(da);
    do @(negedge clk); while (!cmd_ready_o);
    @(posedge clk); #2;
    cmd_valid_i = 1'b0;
    cmd_ssize_i = SW'($urandom);
    cmd_dsize_i = SW'($urandom);
    cmd_soff_i  = OW'($urandom);
    cmd_doff_i  = OW'($urandom);
    for (int k = 0; k < T / S; k++) begin
      bit fired;
      fired = 1'b0;
      while (!fired) begin
        rd_data_i = {$urandom, $urandom};
        if ($urandom % 3 == 0) begin
          rd_valid_i = 1'b0;
        end else begin
          rd_valid_i = 1'b1;
          for (int j = 0; j < S; j++) rd_data_i[8*((sa + k*S + j) % BB) +: 8] = pay[k*S + j];
        end
        @(negedge clk);
        fired = rd_valid_i && rd_ready_o;
        @(posedge clk); #2;
      end
    end
    reads_done = 1'b1;
    rd_valid_i = 1'b0;
    rd_data_i  = {$urandom, $urandom};
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(wr_cnt == T / D, "R2 R3 write beat count", 64'(wr_cnt), 64'(T / D));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready_o && !rd_ready_o && !wr_valid_o && wr_strb_o == '0, "R1 state in reset",
        {60'd0, cmd_ready_o, rd_ready_o, wr_valid_o, |wr_strb_o}, 64'h8);
    @(posedge clk); #2;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_ready_o && !rd_ready_o && !wr_valid_o && wr_strb_o == '0, "R1 state after reset",
        {60'd0, cmd_ready_o, rd_ready_o, wr_valid_o, |wr_strb_o}, 64'h8);
    // packing 2-byte reads into a 4-byte write, then the reverse split
    xfer(1, 2, 6, 4);
    xfer(2, 1, 4, 2);
    for (int pass = 0; pass < 4; pass++) begin
      stall_en = (pass >= 2);
      for (int s = 0; s <= OW; s++) begin
        for (int d = 0; d <= OW; d++) begin
          int sa, da;
          sa = int'($urandom % BB) & ~((1 << s) - 1);
          da = int'($urandom % BB) & ~((1 << d) - 1);
          xfer(s, d, sa, da);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule